// File: doc/BRIEF.md
# Power Management State Controller

This block is the digital sequencing state machine of a battery-powered power management unit. It watches a supply-valid comparator flag, an overtemperature flag and a battery-cover pin. When all three are healthy, it ramps the main and core converters and then the linear regulators, in a selectable order. A release timer holds four active-low status and reset outputs low until the rails have had time to settle. The battery-cover pin passes through an internal debouncer before the state machine uses it.

Once running, the processor can request a low-power mode. It sets an enable register bit and raises a pin, and the mode is entered only on the rising edge of the AND of the two. In low-power mode the main converter stays on. The core converter either turns off or moves to a low-power voltage code. Each linear regulator either turns off or drops into a reduced-quiescent sleep mode. Any of the three faults forces shutdown from every state. Shutdown clears by itself when the faults are gone, and the full sequence then runs again. A hot-reset pulse in the on state re-runs the sequence and the release timer. Register bits arrive as plain inputs, and the block runs on one slow clock with a synchronous active-high reset.

Top module: `pmu_state_ctrl`

## Requirements
- R1: During and directly after reset, all converter and regulator enables, all sleep controls and the four active-low status outputs are 0.
- R2: No enable rises while `supply_ok` is 0 or the filtered cover is low. Once both become healthy, the ramp starts without any other input.
- R3: In the ramp, the first converter (main when `seq_sel`=0, core when `seq_sel`=1) turns on in the first ramp cycle. The other converter turns on SEQ_GAP cycles later, and both regulators turn on 2*SEQ_GAP cycles after the first.
- R4: The four status outputs rise together exactly RELEASE_TICKS cycles after the first converter turns on, and only while the main converter is on.
- R5: A fault during the ramp aborts it: all enables go to 0 and the status outputs stay 0 one cycle later.
- R6: Low-power mode is entered one cycle after a rising edge of (`lp_pin` AND `lp_enable`). A high `lp_pin` with `lp_enable`=0 has no effect.
- R7: In low-power mode `main_en` stays 1. `core_en` is the inverse of `core_off`, and `core_vsel` equals `core_lp_sel`. Outside low-power mode, `core_vsel` equals `core_run_sel`.
- R8: In low-power mode, regulator i is off with sleep 0 when `ldo_lp_off[i]`=1. When `ldo_lp_off[i]`=0 it is on with sleep 1. Sleep is never 1 for a disabled regulator.
- R9: Low-power mode returns to the on state one cycle after `lp_pin` falls or a `hot_rst` or `pbutton` pulse. The status outputs stay high.
- R10: A low `supply_ok` or a high `over_temp` turns off all enables and status outputs one cycle later, from the on or low-power state. When the fault clears, the full sequence and timer run again.
- R11: A `hot_rst` pulse in the on state drops the status outputs one cycle later. They return high RELEASE_TICKS cycles after that.
- R12: The cover filter changes only after DEB_LEN consecutive differing samples. A low pulse of fewer cycles is ignored. A sustained low cover pin drops `main_en` DEB_LEN+3 cycles after the pin falls.
- R13: After an exit from low-power mode with `lp_pin` and `lp_enable` still high, the mode is not re-entered until a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above undervoltage threshold |
| over_temp | input | 1 | Junction overtemperature flag |
| cover_pin | input | 1 | Raw battery-cover pin, high when closed |
| lp_pin | input | 1 | Low-power request pin |
| hot_rst | input | 1 | Hot-reset request, active high |
| pbutton | input | 1 | Push-button event, active high |
| seq_sel | input | 1 | Ramp order: 0 main first, 1 core first |
| lp_enable | input | 1 | Register bit gating low-power entry |
| core_off | input | 1 | Register bit: core converter off in low-power mode |
| core_run_sel | input | 2 | Core voltage code for normal operation |
| core_lp_sel | input | 2 | Core voltage code for low-power mode |
| ldo_lp_off | input | N_LDO | Per regulator: 1 off, 0 sleep in low-power mode |
| main_en | output | 1 | Main converter enable |
| core_en | output | 1 | Core converter enable |
| core_vsel | output | 2 | Core voltage code in use |
| ldo_en | output | N_LDO | Linear regulator enables |
| ldo_sleep | output | N_LDO | Regulator reduced-power controls |
| por_n | output | 1 | Power-on reset, active low |
| pfail_n | output | 1 | Power-fail flag, active low |
| irq_n | output | 1 | Interrupt, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
The hardest case to reach from the ports is low-power re-entry after an exit that left the request AND still high (R13). The bench gets there by entering low-power mode, leaving it with a push-button pulse while pin and enable stay asserted, and then confirming over several cycles that the core voltage code stays at the run value. A fresh edge made by lowering and raising the pin must then re-enter the mode. The cover-debounce latency is also hard to reach, because it spans synchronizer, filter, state and output registers. The bench holds the pin low and counts cycles until `main_en` falls, and sends a shorter glitch to confirm that no such drop follows.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [2:0] {
    PS_IDLE = 3'd0,
    PS_RAMP = 3'd1,
    PS_ON   = 3'd2,
    PS_LOWP = 3'd3,
    PS_SHUT = 3'd4
  } pmu_state_e;
endpackage

// File: rtl/pmu_cover_filter.sv
module pmu_cover_filter #(
  parameter int LEN = 16,
  parameter int CW  = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin,
  output logic          filt,
  output logic [CW-1:0] cnt
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      filt <= 1'b0;
      cnt  <= '0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      if (s2 == filt) begin
        cnt <= '0;
      end else if (cnt == CW'(LEN - 1)) begin
        filt <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmu_release_timer.sv
module pmu_release_timer #(
  parameter int TICKS = 1024,
  parameter int TW    = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  output logic [TW-1:0] cnt,
  output logic          done
);
  assign done = (cnt == TW'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmu_state_ctrl.sv
module pmu_state_ctrl #(
  parameter int DEB_LEN       = 16,
  parameter int RELEASE_TICKS = 1024,
  parameter int SEQ_GAP       = 8,
  parameter int N_LDO         = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok,
  input  logic             over_temp,
  input  logic             cover_pin,
  input  logic             lp_pin,
  input  logic             hot_rst,
  input  logic             pbutton,
  input  logic             seq_sel,
  input  logic             lp_enable,
  input  logic             core_off,
  input  logic [1:0]       core_run_sel,
  input  logic [1:0]       core_lp_sel,
  input  logic [N_LDO-1:0] ldo_lp_off,
  output logic             main_en,
  output logic             core_en,
  output logic [1:0]       core_vsel,
  output logic [N_LDO-1:0] ldo_en,
  output logic [N_LDO-1:0] ldo_sleep,
  output logic             por_n,
  output logic             pfail_n,
  output logic             irq_n,
  output logic             cpu_rst_n
);
  import pmu_pkg::*;

  localparam int DW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
  localparam int TW = (RELEASE_TICKS > 1) ? $clog2(RELEASE_TICKS) : 1;

  pmu_state_e    state_q, state_d;
  logic          cover_ok;
  logic [DW-1:0] deb_cnt;
  logic [TW-1:0] tmr_cnt, step_d;
  logic          tmr_done;
  logic          fault, lp_req, lp_req_q, lp_rise;
  logic          second_on, ldo_on;
  logic          main_d, core_d, stat_d;
  logic [1:0]    vsel_d;
  logic          main_q, core_q, stat_q;
  logic [1:0]    vsel_q;

  pmu_cover_filter #(.LEN(DEB_LEN), .CW(DW)) u_cover (
    .clk(clk), .rst(rst), .pin(cover_pin), .filt(cover_ok), .cnt(deb_cnt)
  );

  pmu_release_timer #(.TICKS(RELEASE_TICKS), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .clr(state_q != PS_RAMP), .run(state_q == PS_RAMP),
    .cnt(tmr_cnt), .done(tmr_done)
  );

  assign fault   = !supply_ok || over_temp || !cover_ok;
  assign lp_req  = lp_pin && lp_enable;
  assign lp_rise = lp_req && !lp_req_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE, PS_SHUT: if (!fault) state_d = PS_RAMP;
      PS_RAMP: begin
        if (fault)         state_d = PS_SHUT;
        else if (tmr_done) state_d = PS_ON;
      end
      PS_ON: begin
        if (fault)        state_d = PS_SHUT;
        else if (hot_rst) state_d = PS_RAMP;
        else if (lp_rise) state_d = PS_LOWP;
      end
      PS_LOWP: begin
        if (fault)                            state_d = PS_SHUT;
        else if (!lp_pin || hot_rst || pbutton) state_d = PS_ON;
      end
      default: state_d = PS_SHUT;
    endcase
  end

  // step index the ramp will hold after this edge
  assign step_d    = (state_q == PS_RAMP) ? tmr_cnt + 1'b1 : '0;
  assign second_on = int'(step_d) >= SEQ_GAP;
  assign ldo_on    = int'(step_d) >= 2 * SEQ_GAP;

  always_comb begin
    main_d = 1'b0;
    core_d = 1'b0;
    stat_d = 1'b0;
    vsel_d = (state_d == PS_LOWP) ? core_lp_sel : core_run_sel;
    unique case (state_d)
      PS_RAMP: begin
        main_d = seq_sel ? second_on : 1'b1;
        core_d = seq_sel ? 1'b1 : second_on;
      end
      PS_ON: begin
        main_d = 1'b1;
        core_d = 1'b1;
        stat_d = 1'b1;
      end
      PS_LOWP: begin
        main_d = 1'b1;
        core_d = !core_off;
        stat_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_IDLE;
      lp_req_q <= 1'b0;
      main_q   <= 1'b0;
      core_q   <= 1'b0;
      stat_q   <= 1'b0;
      vsel_q   <= 2'b00;
    end else begin
      state_q  <= state_d;
      lp_req_q <= lp_req;
      main_q   <= main_d;
      core_q   <= core_d;
      stat_q   <= stat_d;
      vsel_q   <= vsel_d;
    end
  end

  for (genvar i = 0; i < N_LDO; i++) begin : g_ldo
    logic en_d, sl_d, en_q, sl_q;
    always_comb begin
      en_d = 1'b0;
      sl_d = 1'b0;
      unique case (state_d)
        PS_RAMP: en_d = ldo_on;
        PS_ON:   en_d = 1'b1;
        PS_LOWP: begin
          en_d = !ldo_lp_off[i];
          sl_d = !ldo_lp_off[i];
        end
        default: ;
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q <= 1'b0;
        sl_q <= 1'b0;
      end else begin
        en_q <= en_d;
        sl_q <= sl_d;
      end
    end
    assign ldo_en[i]    = en_q;
    assign ldo_sleep[i] = sl_q;
  end

  assign main_en   = main_q;
  assign core_en   = core_q;
  assign core_vsel = vsel_q;
  assign por_n     = stat_q;
  assign pfail_n   = stat_q;
  assign irq_n     = stat_q;
  assign cpu_rst_n = stat_q;
endmodule

module pmu_state_ctrl_chk #(
  parameter int DEB_LEN = 16,
  parameter int DW      = 4,
  parameter int N_LDO   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             supply_ok,
  input logic             over_temp,
  input logic             cover_ok,
  input logic [DW-1:0]    deb_cnt,
  input logic             tmr_done,
  input logic             main_en,
  input logic             core_en,
  input logic [N_LDO-1:0] ldo_en,
  input logic [N_LDO-1:0] ldo_sleep,
  input logic             por_n
);
  AST_FAULT_SHUTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok || over_temp || !cover_ok) |=> (!main_en && !core_en && ldo_en == '0 && !por_n)); // R10
  AST_STATUS_NEEDS_MAIN: assert property (@(posedge clk) disable iff (rst)
    por_n |-> main_en); // R4
  AST_RELEASE_AFTER_TIMER: assert property (@(posedge clk) disable iff (rst)
    $rose(por_n) |-> $past(tmr_done)); // R4
  AST_SLEEP_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (ldo_sleep & ~ldo_en) == '0); // R8
  AST_SLEEP_KEEPS_MAIN: assert property (@(posedge clk) disable iff (rst)
    (ldo_sleep != '0) |-> main_en); // R7
  AST_COVER_DEBOUNCED: assert property (@(posedge clk) disable iff (rst)
    !$stable(cover_ok) |-> (int'($past(deb_cnt)) == DEB_LEN - 1)); // R12
endmodule

bind pmu_state_ctrl pmu_state_ctrl_chk #(.DEB_LEN(DEB_LEN), .DW(DW), .N_LDO(N_LDO)) u_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .over_temp(over_temp),
  .cover_ok(cover_ok), .deb_cnt(deb_cnt), .tmr_done(tmr_done),
  .main_en(main_en), .core_en(core_en), .ldo_en(ldo_en),
  .ldo_sleep(ldo_sleep), .por_n(por_n)
);

// File: tb/pmu_state_ctrl_test.sv
module pmu_state_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 16;
  localparam int RT  = 24;
  localparam int GAP = 3;
  localparam int NL  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0, over_temp = 1'b0, cover_pin = 1'b0;
  logic lp_pin = 1'b0, hot_rst = 1'b0, pbutton = 1'b0, seq_sel = 1'b0;
  logic lp_enable = 1'b0, core_off = 1'b0;
  logic [1:0] core_run_sel = 2'd1, core_lp_sel = 2'd2;
  logic [NL-1:0] ldo_lp_off = '0;
  logic main_en, core_en, por_n, pfail_n, irq_n, cpu_rst_n;
  logic [1:0] core_vsel;
  logic [NL-1:0] ldo_en, ldo_sleep;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pmu_state_ctrl #(.DEB_LEN(DEB), .RELEASE_TICKS(RT), .SEQ_GAP(GAP), .N_LDO(NL)) uut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .over_temp(over_temp),
    .cover_pin(cover_pin), .lp_pin(lp_pin), .hot_rst(hot_rst), .pbutton(pbutton),
    .seq_sel(seq_sel), .lp_enable(lp_enable), .core_off(core_off),
    .core_run_sel(core_run_sel), .core_lp_sel(core_lp_sel), .ldo_lp_off(ldo_lp_off),
    .main_en(main_en), .core_en(core_en), .core_vsel(core_vsel), .ldo_en(ldo_en),
    .ldo_sleep(ldo_sleep), .por_n(por_n), .pfail_n(pfail_n), .irq_n(irq_n),
    .cpu_rst_n(cpu_rst_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int status_bits();
    return {por_n, pfail_n, irq_n, cpu_rst_n};
  endfunction

  function automatic int all_off();
    return int'(!main_en && !core_en && ldo_en == '0 && ldo_sleep == '0 && status_bits() == 0);
  endfunction

  // waits for the ramp to start, then measures the enable offsets and release time
  task automatic bring_up(input string tag);
    int k, t2, tl, tp;
    k = 0;
    while (!(main_en || core_en) && k < 200) begin step(); k++; end
    chk({tag, " R2 ramp started"}, int'(main_en || core_en), 1);
    chk({tag, " R3 first converter"}, {main_en, core_en}, seq_sel ? 1 : 2);
    t2 = -1; tl = -1; tp = -1;
    for (int j = 0; j <= RT + 4; j++) begin
      if (t2 < 0 && main_en && core_en) t2 = j;
      if (tl < 0 && ldo_en == '1) tl = j;
      if (tp < 0 && status_bits() == 15) tp = j;
      if (j < RT + 4) step();
    end
    chk({tag, " R3 second converter offset"}, t2, GAP);
    chk({tag, " R3 regulator offset"}, tl, 2 * GAP);
    chk({tag, " R4 status release offset"}, tp, RT);
  endtask

  task automatic count_release(input string tag);
    int k;
    k = 0;
    while (status_bits() != 15 && k < RT + 10) begin step(); k++; end
    chk(tag, k, RT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int k;
    int bad;
    supply_ok = 1'b1;
    cover_pin = 1'b0;
    step(3);
    chk("R1 reset outputs", all_off(), 1);
    rst = 1'b0;
    step();
    chk("R1 after reset outputs", all_off(), 1);

    // R2: cover low, then supply low
    step(60);
    chk("R2 cover low holds off", all_off(), 1);
    supply_ok = 1'b0;
    cover_pin = 1'b1;
    step(60);
    chk("R2 supply low holds off", all_off(), 1);
    supply_ok = 1'b1;
    bring_up("boot seq0");
    chk("R7 run vsel in on state", core_vsel, 1);

    // R6: pin high without enable bit
    lp_pin = 1'b1;
    step(4);
    chk("R6 no entry without enable", core_vsel, 1);
    lp_enable = 1'b1;
    step();
    chk("R6 entry on AND edge", core_vsel, 2);

    // R7 / R8 sweep inside low-power mode
    for (int off = 0; off < 2; off++)
      for (int sel = 0; sel < 4; sel++)
        for (int lo = 0; lo < 4; lo++) begin
          core_off = off[0];
          core_lp_sel = sel[1:0];
          ldo_lp_off = lo[1:0];
          step();
          chk("R7 main stays on", main_en, 1);
          chk("R7 core enable", core_en, 1 - off);
          chk("R7 core vsel", core_vsel, sel);
          chk("R8 regulator enables", ldo_en, (~lo) & 3);
          chk("R8 regulator sleep", ldo_sleep, (~lo) & 3);
        end
    core_off = 1'b1;
    core_lp_sel = 2'd2;
    ldo_lp_off = 2'b01;
    step();

    // R9 exits
    lp_pin = 1'b0;
    step();
    chk("R9 pin exit core", core_en, 1);
    chk("R9 pin exit vsel", core_vsel, 1);
    chk("R9 pin exit regs", {ldo_en, ldo_sleep}, 4'b1100);
    chk("R9 pin exit status", status_bits(), 15);
    lp_pin = 1'b1;
    step();
    chk("R6 reentry", core_vsel, 2);
    pbutton = 1'b1;
    step();
    pbutton = 1'b0;
    chk("R9 button exit", {core_en, core_vsel}, 3'b101);

    // R13: AND still high, no re-entry
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (core_vsel != 2'd1) bad++;
    end
    chk("R13 no reentry without edge", bad, 0);
    lp_pin = 1'b0;
    step();
    lp_pin = 1'b1;
    step();
    chk("R13 new edge reenters", core_vsel, 2);
    hot_rst = 1'b1;
    step();
    hot_rst = 1'b0;
    chk("R9 hot reset exit", {core_en, core_vsel, por_n}, 4'b1011);
    lp_pin = 1'b0;
    step();

    // R11 hot reset in on state
    hot_rst = 1'b1;
    step();
    hot_rst = 1'b0;
    chk("R11 status drops", status_bits(), 0);
    count_release("R11 status returns");

    // R10 supply fault from on
    supply_ok = 1'b0;
    step();
    chk("R10 supply fault off", all_off(), 1);
    step(10);
    chk("R10 stays off", all_off(), 1);
    supply_ok = 1'b1;
    step();
    chk("R10 restart after supply", int'(main_en && !por_n), 1);
    count_release("R10 rerun timer");

    // R10 overtemp from low-power mode
    lp_pin = 1'b1;
    step();
    chk("R6 entry before fault", core_vsel, 2);
    over_temp = 1'b1;
    step();
    chk("R10 overtemp in lp off", all_off(), 1);
    over_temp = 1'b0;
    lp_pin = 1'b0;
    bring_up("after overtemp");

    // R5 fault during ramp
    supply_ok = 1'b0;
    step(2);
    supply_ok = 1'b1;
    step(2);
    chk("R5 ramp running", int'(main_en && !por_n), 1);
    over_temp = 1'b1;
    step();
    chk("R5 ramp aborted", all_off(), 1);
    over_temp = 1'b0;
    bring_up("after ramp abort");

    // R12 glitch ignored
    cover_pin = 1'b0;
    step(DEB - 4);
    cover_pin = 1'b1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (!main_en || status_bits() != 15) bad++;
    end
    chk("R12 short glitch ignored", bad, 0);

    // R12 sustained cover low latency
    cover_pin = 1'b0;
    k = 0;
    while (main_en && k < 60) begin step(); k++; end
    chk("R12 cover drop latency", k, DEB + 3);
    chk("R10 cover fault off", all_off(), 1);

    // R3 core-first order on restart
    seq_sel = 1'b1;
    cover_pin = 1'b1;
    bring_up("seq1");

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule